// File: doc/BRIEF.md
# Fault Event Interrupt Controller

This block decides when a single interrupt message is sent for fault events. It keeps five status bits and a 32-bit control word that holds a mask bit and a pending flag. Hardware event pulses set the status bits. Software clears status bits by writing ones, writes the mask, and reads the control word.

An interrupt condition is raised only when the status set goes from all-clear to having at least one bit set. That condition makes the message pending. When the mask is clear and the transient hold input is low, a send request is raised. The request stays up until the environment acknowledges it. If software clears every status bit while the message is still pending, the message is dropped and never sent.

The primary-fault status bit is not a flop of its own. It is the OR of a parameterised set of per-record fault flags, so it clears only after every record flag has been cleared.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset, `ctl_rdata_o` reads 0x80000000 (mask set, pending clear), `sts_o` is zero and `send_req_o` is low.
- R2: An event pulse sets its status bit at the next clock edge. `sts_o` bit 0 is primary fault, bit 1 is advanced fault, bit 2 is queue error, bit 3 is invalid completion and bit 4 is completion timeout. `evt_set_i[k]` drives `sts_o[k+1]`, and a `rec_set_i` bit sets its record flag, which `sts_o[0]` shows as the OR of all record flags.
- R3: An event that arrives while `sts_o` is all zero is a new condition. It sets the pending flag (`ctl_rdata_o[30]`) at the same edge.
- R4: An event that arrives while any status bit is already set does not set the pending flag.
- R5: While the mask (`ctl_rdata_o[31]`) is 1, `send_req_o` stays low and the pending flag is kept.
- R6: While `hold_i` is 1, `send_req_o` stays low and the pending flag is kept.
- R7: `send_req_o` is high exactly when pending is 1, the mask is 0 and `hold_i` is 0. It stays high until `send_ack_i` is seen, and the pending flag clears at the edge where the acknowledge is taken.
- R8: Writing ones to `sts_clr_i` clears the matching non-primary status bits. Writing ones to `rec_clr_i` clears record flags, and `sts_o[0]` stays set until every record flag is clear.
- R9: When every status bit becomes clear, the pending flag clears and no request is issued for it.
- R10: If a set and a clear hit the same status bit in one cycle, the bit ends up set. A new condition that coincides with a clear write still sets pending.
- R11: A control write takes only bit 31 (the mask). Writes to bit 30 and bits 29:0 are ignored, and bits 29:0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_set_i | input | NUM_REC | Per-record fault flag set pulses |
| rec_clr_i | input | NUM_REC | Write-one-to-clear of record flags |
| evt_set_i | input | 4 | Set pulses: advanced, queue error, invalid completion, timeout |
| sts_clr_i | input | 4 | Write-one-to-clear of the non-primary status bits |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control write data |
| hold_i | input | 1 | Transient hold of message issue |
| send_ack_i | input | 1 | Acknowledge of the send request |
| ctl_rdata_o | output | 32 | Control word read value |
| sts_o | output | 5 | Status bits |
| send_req_o | output | 1 | Message send request |

## Verification
A pending flag stuck at 1 shows up as a second request after an acknowledge, on the very next cycle. A pending flag stuck at 0 shows up as a missing request as soon as the mask clears. A status bit that fails to clear shows up one cycle after the clear write: `sts_o` stays nonzero and pending is not dropped. A wrong all-clear test shows up at the first event that follows a partly cleared status set, because pending then rises when it should not, or stays low when it should rise. All of these are visible at `sts_o`, `ctl_rdata_o` or `send_req_o` within one clock of the stimulus.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  localparam int STS_W    = 5;
  localparam int EVT_W    = STS_W - 1;
  localparam int CTL_W    = 32;
  localparam int MASK_BIT = 31;
  localparam int PEND_BIT = 30;

  typedef enum logic [2:0] {
    STS_PRI  = 3'd0,
    STS_ADV  = 3'd1,
    STS_QERR = 3'd2,
    STS_ICMP = 3'd3,
    STS_TOUT = 3'd4
  } sts_idx_e;
endpackage

// File: rtl/fault_rec_flags.sv
module fault_rec_flags #(
  parameter int NUM_REC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REC-1:0] set_i,
  input  logic [NUM_REC-1:0] clr_i,
  output logic [NUM_REC-1:0] flags_o,
  output logic [NUM_REC-1:0] flags_nxt_o
);
  for (genvar i = 0; i < NUM_REC; i++) begin : g_rec
    // set wins over clear
    assign flags_nxt_o[i] = set_i[i] | (flags_o[i] & ~clr_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[i] <= 1'b0;
      else         flags_o[i] <= flags_nxt_o[i];
    end

    assert_rec_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_o[i]);
  end
endmodule

// File: rtl/fault_evt_bits.sv
module fault_evt_bits #(
  parameter int EVT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] bits_o,
  output logic [EVT_W-1:0] bits_nxt_o
);
  for (genvar k = 0; k < EVT_W; k++) begin : g_bit
    assign bits_nxt_o[k] = set_i[k] | (bits_o[k] & ~clr_i[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bits_o[k] <= 1'b0;
      else         bits_o[k] <= bits_nxt_o[k];
    end

    assert_evt_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> bits_o[k]);
    assert_evt_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !bits_o[k]);
  end
endmodule

// File: rtl/fault_pend_ctl.sv
module fault_pend_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sts_zero_i,
  input  logic sts_nxt_zero_i,
  input  logic set_any_i,
  input  logic mask_we_i,
  input  logic mask_wdata_i,
  input  logic hold_i,
  input  logic ack_i,
  output logic pend_o,
  output logic mask_o,
  output logic req_o
);
  logic new_cond;
  logic pend_d;

  assign new_cond = sts_zero_i & set_any_i;
  assign req_o    = pend_o & ~mask_o & ~hold_i;

  always_comb begin
    pend_d = pend_o;
    if (new_cond)            pend_d = 1'b1;
    else if (req_o && ack_i) pend_d = 1'b0;
    else if (sts_nxt_zero_i) pend_d = 1'b0; // all serviced: drop unsent
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      mask_o <= 1'b1;
    end else begin
      pend_o <= pend_d;
      if (mask_we_i) mask_o <= mask_wdata_i;
    end
  end

  assert_new_cond_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_zero_i && set_any_i) |=> pend_o);
  assert_pend_only_new_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(sts_zero_i && set_any_i));
  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && !(sts_zero_i && set_any_i)) |=> !pend_o);
  assert_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && sts_nxt_zero_i && !(sts_zero_i && set_any_i)) |=> !pend_o);
  assert_pend_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !req_o && !sts_nxt_zero_i) |=> pend_o);
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int NUM_REC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REC-1:0] rec_set_i,
  input  logic [NUM_REC-1:0] rec_clr_i,
  input  logic [EVT_W-1:0]   evt_set_i,
  input  logic [EVT_W-1:0]   sts_clr_i,
  input  logic               ctl_we_i,
  input  logic [CTL_W-1:0]   ctl_wdata_i,
  input  logic               hold_i,
  input  logic               send_ack_i,
  output logic [CTL_W-1:0]   ctl_rdata_o,
  output logic [STS_W-1:0]   sts_o,
  output logic               send_req_o
);
  logic [NUM_REC-1:0] rec_q, rec_nxt;
  logic [EVT_W-1:0]   evt_q, evt_nxt;
  logic               pend_q, mask_q;
  logic               sts_zero, sts_nxt_zero, set_any;
  logic               unused_wdata;

  assign unused_wdata = ^ctl_wdata_i[PEND_BIT:0];

  fault_rec_flags #(.NUM_REC(NUM_REC)) u_rec (
    .clk_i, .rst_ni,
    .set_i      (rec_set_i),
    .clr_i      (rec_clr_i),
    .flags_o    (rec_q),
    .flags_nxt_o(rec_nxt)
  );

  fault_evt_bits #(.EVT_W(EVT_W)) u_evt (
    .clk_i, .rst_ni,
    .set_i     (evt_set_i),
    .clr_i     (sts_clr_i),
    .bits_o    (evt_q),
    .bits_nxt_o(evt_nxt)
  );

  assign sts_o        = {evt_q, |rec_q};
  assign sts_zero     = (sts_o == '0);
  assign sts_nxt_zero = ~(|rec_nxt) & ~(|evt_nxt);
  assign set_any      = (|rec_set_i) | (|evt_set_i);

  fault_pend_ctl u_pend (
    .clk_i, .rst_ni,
    .sts_zero_i    (sts_zero),
    .sts_nxt_zero_i(sts_nxt_zero),
    .set_any_i     (set_any),
    .mask_we_i     (ctl_we_i),
    .mask_wdata_i  (ctl_wdata_i[MASK_BIT]),
    .hold_i        (hold_i),
    .ack_i         (send_ack_i),
    .pend_o        (pend_q),
    .mask_o        (mask_q),
    .req_o         (send_req_o)
  );

  always_comb begin
    ctl_rdata_o           = '0;
    ctl_rdata_o[MASK_BIT] = mask_q;
    ctl_rdata_o[PEND_BIT] = pend_q;
  end

  assert_pend_needs_sts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (sts_o != '0));
  assert_pri_or_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_q != '0) |-> sts_o[STS_PRI]);
endmodule

// File: tb/fault_irq_ctrl_tb.sv
module fault_irq_ctrl_tb;
  localparam int NR = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [NR-1:0] rec_set_i = '0, rec_clr_i = '0;
  logic [3:0]  evt_set_i = '0, sts_clr_i = '0;
  logic        ctl_we_i = 1'b0;
  logic [31:0] ctl_wdata_i = '0;
  logic        hold_i = 1'b0, send_ack_i = 1'b0;
  logic [31:0] ctl_rdata_o;
  logic [4:0]  sts_o;
  logic        send_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fault_irq_ctrl #(.NUM_REC(NR)) u_dut (.*);

  typedef struct packed {
    logic [7:0] tag;
    logic [3:0] rs, es, rc, sc;
    logic       we, m, hold, ack;
    logic [4:0] e_sts;
    logic       e_pend, e_mask, e_req;
  } vec_t;

  // tag = requirement number exercised by the row
  localparam vec_t VECS [18] = '{
    '{8'd3,  4'h0,4'h1,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b00010, 1'b1,1'b1,1'b0}, // R3 advanced event from clear
    '{8'd5,  4'h0,4'h0,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b00010, 1'b1,1'b1,1'b0}, // R5 masked
    '{8'd6,  4'h0,4'h0,4'h0,4'h0, 1'b1,1'b0,1'b1,1'b0, 5'b00010, 1'b1,1'b0,1'b0}, // R6 unmask under hold
    '{8'd7,  4'h0,4'h0,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b00010, 1'b1,1'b0,1'b1}, // R7 request
    '{8'd7,  4'h0,4'h0,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b00010, 1'b1,1'b0,1'b1}, // R7 held until ack
    '{8'd7,  4'h0,4'h0,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b1, 5'b00010, 1'b0,1'b0,1'b0}, // R7 ack clears
    '{8'd4,  4'h0,4'h2,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b00110, 1'b0,1'b0,1'b0}, // R4 not new
    '{8'd8,  4'h0,4'h0,4'h0,4'hF, 1'b0,1'b0,1'b0,1'b0, 5'b00000, 1'b0,1'b0,1'b0}, // R8 w1c
    '{8'd2,  4'h3,4'h0,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b00001, 1'b1,1'b0,1'b1}, // R2 records
    '{8'd8,  4'h0,4'h0,4'h1,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b00001, 1'b1,1'b0,1'b1}, // R8 one record left
    '{8'd9,  4'h0,4'h0,4'h2,4'h0, 1'b0,1'b0,1'b1,1'b0, 5'b00000, 1'b0,1'b0,1'b0}, // R9 drop
    '{8'd9,  4'h0,4'h0,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b00000, 1'b0,1'b0,1'b0}, // R9 no send after hold
    '{8'd10, 4'h0,4'h8,4'h0,4'h8, 1'b0,1'b0,1'b0,1'b0, 5'b10000, 1'b1,1'b0,1'b1}, // R10 set wins
    '{8'd5,  4'h0,4'h0,4'h0,4'h0, 1'b1,1'b1,1'b0,1'b0, 5'b10000, 1'b1,1'b1,1'b0}, // R5 remask
    '{8'd9,  4'h0,4'h0,4'h0,4'h8, 1'b0,1'b0,1'b0,1'b0, 5'b00000, 1'b0,1'b1,1'b0}, // R9 masked drop
    '{8'd3,  4'h0,4'h4,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b0, 5'b01000, 1'b1,1'b1,1'b0}, // R3 invalid completion
    '{8'd7,  4'h0,4'h0,4'h0,4'h0, 1'b1,1'b0,1'b0,1'b0, 5'b01000, 1'b1,1'b0,1'b1}, // R7 unmask sends
    '{8'd7,  4'h0,4'h0,4'h0,4'h0, 1'b0,1'b0,1'b0,1'b1, 5'b01000, 1'b0,1'b0,1'b0}  // R7 ack
  };

  task automatic check(input string req, input logic [37:0] act, input logic [37:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [37:0] snap();
    return {sts_o, ctl_rdata_o, send_req_o};
  endfunction

  task automatic idle();
    rec_set_i = '0; rec_clr_i = '0; evt_set_i = '0; sts_clr_i = '0;
    ctl_we_i = 1'b0; ctl_wdata_i = '0; hold_i = 1'b0; send_ack_i = 1'b0;
  endtask

  task automatic ctl_write(input logic [31:0] d);
    @(negedge clk_i);
    idle();
    ctl_we_i = 1'b1; ctl_wdata_i = d;
    @(posedge clk_i); #2;
    ctl_we_i = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset", snap(), {5'b0, 32'h8000_0000, 1'b0});

    for (int i = 0; i < 18; i++) begin
      @(negedge clk_i);
      rec_set_i = VECS[i].rs; evt_set_i = VECS[i].es;
      rec_clr_i = VECS[i].rc; sts_clr_i = VECS[i].sc;
      ctl_we_i = VECS[i].we; ctl_wdata_i = {VECS[i].m, 31'b0};
      hold_i = VECS[i].hold; send_ack_i = VECS[i].ack;
      @(posedge clk_i); #2;
      n_chk++;
      if (snap() !== {VECS[i].e_sts, VECS[i].e_mask, VECS[i].e_pend, 30'b0, VECS[i].e_req}) begin
        n_fail++;
        $display("FAIL R%0d vec %0d: actual %h expected %h", VECS[i].tag, i, snap(),
                 {VECS[i].e_sts, VECS[i].e_mask, VECS[i].e_pend, 30'b0, VECS[i].e_req});
      end
    end

    // R11: only bit 31 of a write lands
    ctl_write(32'hC000_0000);
    check("R11 mask only", snap(), {5'b01000, 32'h8000_0000, 1'b0});
    ctl_write(32'h7FFF_FFFF);
    check("R11 reserved ignored", snap(), {5'b01000, 32'h0000_0000, 1'b0});

    // R10: record set and clear in one cycle while clear -> set wins, pending
    @(negedge clk_i); idle(); sts_clr_i = 4'hF;
    @(posedge clk_i); #2;
    @(negedge clk_i); idle(); rec_set_i = 4'h4; rec_clr_i = 4'h4; hold_i = 1'b1;
    @(posedge clk_i); #2;
    check("R10 record set wins", snap(), {5'b00001, 32'h4000_0000, 1'b0});

    // R6: hold released -> request
    @(negedge clk_i); idle();
    #1;
    check("R6 hold release", snap(), {5'b00001, 32'h4000_0000, 1'b1});

    // R1: asynchronous reset mid-run
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R1 async reset", snap(), {5'b0, 32'h8000_0000, 1'b0});
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", snap(), {5'b0, 32'h8000_0000, 1'b0});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule